// File: doc/BRIEF.md
# Edge-Started Byte-Wide Persistent Memory Core

This block is a clocked, synthesizable model of a byte-wide parallel memory. Every access begins when the active-low chip enable is seen to fall on the system clock. At that edge the address is captured and the cycle is classified as a read or a write. The access delay and the precharge recovery are counted in clocks. The stored array keeps its contents across reset. The bidirectional data bus is split into an input byte, an output byte and a drive flag. A surrounding pad ring or bus fabric turns these into a tri-state bus.

A host runs a cycle in four steps. It lowers chip enable. It holds it low for at least the access time. It then raises chip enable and leaves it high for the precharge time before the next fall. If write enable is already low at the fall, the cycle is a silent write. If write enable drops later, the cycle begins as a read and turns into a write. In both cases the byte written is the one on the input bus when the first of chip enable or write enable rises. The array holds 2**ADDR_W bytes. ADDR_W = 15 gives the full 32,768-byte part. The default is smaller to keep elaboration light.

Top module: `pmem_core`

## Requirements
- R1: The array stores 2**ADDR_W bytes; a byte written to an address is returned by a later read of that address, and the array is not cleared by reset.
- R2: A cycle starts only at a clock edge where ce_n is sampled low after being sampled high. The address is captured at that edge, and any later change of addr has no effect on that cycle. Holding ce_n low starts no further cycle.
- R3: If we_n is sampled low at the starting edge, the cycle is a write and dout_en stays 0 for the whole cycle, whatever oe_n does.
- R4: If we_n is high at the start, the cycle is a read. dout_en follows oe_n while data is valid and drops to 0 as soon as we_n goes low. It stays 0 for the rest of that cycle.
- R5: A write takes the din value sampled at the first edge where ce_n or we_n is sampled high after the write began. Only one write happens per cycle; a second we_n pulse in the same cycle writes nothing.
- R6: If the starting edge is E0, read data becomes valid after edge E0+ACCESS_CLKS. dout_en is 0 before that, and dout is 0 whenever dout_en is 0.
- R7: When ce_n is first sampled high after the access has finished, a precharge of PRECHARGE_CLKS edges begins. A fall sampled at the edge right after precharge ends is accepted as a new cycle.
- R8: A ce_n fall sampled while a cycle or precharge is in progress is ignored and sets protocol_error. protocol_error stays 1 until reset.
- R9: If ce_n rises before the access time has elapsed, the cycle still completes internally. No data is driven, and precharge follows the completion.
- R10: After reset, dout_en and protocol_error are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; its falling edge starts a cycle |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address, captured at cycle start |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | High while the block drives the bus |
| protocol_error | output | 1 | Sticky flag for a rejected cycle start |

## Verification
The assertions take for granted that ce_n, we_n and oe_n are already synchronous to clk and only change between edges. They also assume ce_n is held high throughout reset, so the first fall after reset is a real edge. The stimulus changes every input one time unit after a falling clock edge and sets ce_n high before releasing reset. Precharge violations are produced only on purpose, in a single late test, and reset then clears the sticky flag.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_READY  = 2'd2,
    PH_PRECH  = 2'd3
  } phase_t;

  // Counter width able to hold values 0 .. max(a,b)-1.
  function automatic int unsigned span_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // True on the final clock of a window of len clocks, counted from 0.
  function automatic logic window_last(int unsigned cnt, int unsigned len);
    return (cnt + 1) >= len;
  endfunction

endpackage

// File: rtl/pmem_fall_detect.sv
module pmem_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic ce_fall
);
  logic ce_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_prev <= 1'b1;
    else        ce_prev <= ce_n;
  end

  assign ce_fall = ce_prev & ~ce_n;
endmodule

// File: rtl/pmem_phase_seq.sv
module pmem_phase_seq
  import pmem_pkg::*;
#(
  parameter int ACCESS_CLKS    = 3,
  parameter int PRECHARGE_CLKS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ce_n,
  input  logic   ce_fall,
  output phase_t phase,
  output logic   cyc_start,
  output logic   start_rejected,
  output logic   access_done,
  output logic   ce_released
);
  localparam int CNT_W = span_width(ACCESS_CLKS, PRECHARGE_CLKS);

  logic [CNT_W-1:0] cnt;
  logic             rel_q;
  logic             prech_done;

  assign cyc_start      = ce_fall && (phase == PH_IDLE);
  assign start_rejected = ce_fall && (phase != PH_IDLE);
  assign access_done    = (phase == PH_ACCESS) && window_last(32'(cnt), ACCESS_CLKS);
  assign prech_done     = (phase == PH_PRECH)  && window_last(32'(cnt), PRECHARGE_CLKS);
  assign ce_released    = rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      rel_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (cyc_start) begin
            phase <= PH_ACCESS;
            cnt   <= '0;
            rel_q <= 1'b0;
          end
        end
        PH_ACCESS: begin
          rel_q <= rel_q | ce_n;
          if (access_done) begin
            cnt   <= '0;
            phase <= (rel_q | ce_n) ? PH_PRECH : PH_READY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_READY: begin
          if (ce_n) begin
            phase <= PH_PRECH;
            cnt   <= '0;
            rel_q <= 1'b1;
          end
        end
        PH_PRECH: begin
          if (prech_done) phase <= PH_IDLE;
          else            cnt   <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmem_write_ctl.sv
module pmem_write_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic in_cycle,
  input  logic ce_released,
  input  logic ce_n,
  input  logic we_n,
  output logic cyc_write,
  output logic wr_commit
);
  logic wr_open;
  logic late_open;

  // Write window closes on whichever enable is seen high first.
  assign wr_commit = in_cycle && wr_open && !ce_released && (ce_n || we_n);
  // Read cycle turning into a write when write enable drops.
  assign late_open = in_cycle && !cyc_write && !ce_released && !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_write <= 1'b0;
      wr_open   <= 1'b0;
    end else if (cyc_start) begin
      cyc_write <= !we_n;
      wr_open   <= !we_n;
    end else begin
      if (wr_commit) wr_open <= 1'b0;
      if (late_open) begin
        cyc_write <= 1'b1;
        wr_open   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmem_array.sv
module pmem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read returns the old byte if a write hits the same address on the same edge.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/pmem_core.sv
module pmem_core
  import pmem_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int DATA_W         = 8,
  parameter int ACCESS_CLKS    = 3,
  parameter int PRECHARGE_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              protocol_error
);
  phase_t            phase;
  logic              ce_fall;
  logic              cyc_start;
  logic              start_rejected;
  logic              access_done;
  logic              ce_released;
  logic              cyc_write;
  logic              wr_commit;
  logic              in_cycle;
  logic              phase_is_prech;
  logic              data_ready;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data;
  logic              err_q;

  pmem_fall_detect u_fall (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .ce_fall (ce_fall)
  );

  pmem_phase_seq #(
    .ACCESS_CLKS    (ACCESS_CLKS),
    .PRECHARGE_CLKS (PRECHARGE_CLKS)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .ce_n           (ce_n),
    .ce_fall        (ce_fall),
    .phase          (phase),
    .cyc_start      (cyc_start),
    .start_rejected (start_rejected),
    .access_done    (access_done),
    .ce_released    (ce_released)
  );

  assign in_cycle       = (phase == PH_ACCESS) || (phase == PH_READY);
  assign phase_is_prech = (phase == PH_PRECH);
  assign data_ready     = (phase == PH_READY);

  pmem_write_ctl u_wctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start   (cyc_start),
    .in_cycle    (in_cycle),
    .ce_released (ce_released),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .cyc_write   (cyc_write),
    .wr_commit   (wr_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (cyc_start) addr_q <= addr;
  end

  pmem_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk     (clk),
    .wr_en   (wr_commit),
    .wr_addr (addr_q),
    .wr_data (din),
    .rd_en   (access_done),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (start_rejected) err_q <= 1'b1;
  end

  assign protocol_error = err_q;
  assign dout_en = data_ready && !cyc_write && !ce_n && !oe_n && we_n;
  assign dout    = dout_en ? rd_data : '0;
endmodule

// File: rtl/pmem_core_chk.sv
module pmem_core_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic dout_en,
  input logic protocol_error,
  input logic cyc_start,
  input logic start_rejected,
  input logic wr_commit,
  input logic phase_is_prech
);
  logic       cew_seen;
  logic [1:0] commits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cew_seen <= 1'b0;
      commits  <= '0;
    end else if (cyc_start) begin
      cew_seen <= !we_n;
      commits  <= '0;
    end else if (wr_commit && commits != 2'd3) begin
      commits <= commits + 2'd1;
    end
  end

  a_r2_start_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> ($past(ce_n) && !ce_n));

  a_r6_quiet_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> !dout_en);

  a_r3_cewrite_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !cew_seen);

  a_r4_we_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dout_en);

  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (commits == 2'd0));

  a_r7_no_start_in_prech: assert property (@(posedge clk) disable iff (!rst_n)
    phase_is_prech |-> !cyc_start);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_error |=> protocol_error);

  a_r8_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    start_rejected |=> protocol_error);
endmodule

bind pmem_core pmem_core_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ce_n           (ce_n),
  .we_n           (we_n),
  .dout_en        (dout_en),
  .protocol_error (protocol_error),
  .cyc_start      (cyc_start),
  .start_rejected (start_rejected),
  .wr_commit      (wr_commit),
  .phase_is_prech (phase_is_prech)
);

// File: tb/tb_pmem_core.sv
module tb_pmem_core;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int AC = 3;
  localparam int PC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en, protocol_error;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  pmem_core #(.ADDR_W(AW), .DATA_W(DW), .ACCESS_CLKS(AC), .PRECHARGE_CLKS(PC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .protocol_error(protocol_error)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: stage 0 idle, 1 waiting, 2 data valid, 3 recovering.
  logic [DW-1:0] ref_mem [int];
  int  m_stage, m_count, m_addr, m_data;
  bit  m_rel, m_wkind, m_wopen, m_err, m_last_ce;

  task automatic model_reset();
    m_stage = 0; m_count = 0; m_addr = 0; m_data = -1;
    m_rel = 0; m_wkind = 0; m_wopen = 0; m_err = 0; m_last_ce = 1;
  endtask

  task automatic model_step();
    bit fell, old_rel;
    fell = m_last_ce && !ce_n;
    m_last_ce = ce_n;
    if (fell && m_stage != 0) m_err = 1;
    case (m_stage)
      0: if (fell) begin
        m_stage = 1; m_count = 0; m_rel = 0; m_addr = int'(addr);
        m_wkind = !we_n; m_wopen = !we_n;
      end
      1, 2: begin
        old_rel = m_rel;
        if (m_stage == 1 && m_count == AC - 1)
          m_data = ref_mem.exists(m_addr) ? int'(ref_mem[m_addr]) : -1;
        if (!old_rel) begin
          if (m_wopen && (ce_n || we_n)) begin
            ref_mem[m_addr] = din;
            m_wopen = 0;
          end else if (!m_wkind && !ce_n && !we_n) begin
            m_wkind = 1; m_wopen = 1;
          end
        end
        if (m_stage == 1) begin
          if (m_count == AC - 1) begin
            m_count = 0;
            m_stage = (old_rel || ce_n) ? 3 : 2;
          end else m_count++;
          m_rel = old_rel || ce_n;
        end else if (ce_n) begin
          m_stage = 3; m_count = 0; m_rel = 1;
        end
      end
      default: begin
        if (m_count == PC - 1) m_stage = 0;
        else m_count++;
      end
    endcase
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_en;
      exp_en = (m_stage == 2) && !m_wkind && !ce_n && !oe_n && we_n;
      chk(dout_en == exp_en, "R6", "model dout_en", int'(dout_en), int'(exp_en));
      if (exp_en && m_data >= 0)
        chk(int'(dout) == m_data, "R1", "model dout", int'(dout), m_data);
      if (!exp_en)
        chk(dout == '0, "R6", "undriven dout", int'(dout), 0);
      chk(protocol_error == m_err, "R8", "model protocol_error",
          int'(protocol_error), int'(m_err));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic recover();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    repeat (PC + 1) tick();
  endtask

  task automatic write_ce(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; din = d; we_n = 1'b0; oe_n = 1'b0; ce_n = 1'b0;
    for (int i = 1; i <= AC + 2; i++) begin
      @(negedge clk);
      chk(dout_en == 1'b0, "R3", "ce-write drives bus", int'(dout_en), 0);
      #1;
      addr = ~a;
    end
    ce_n = 1'b1;
    tick();
    we_n = 1'b1;
    repeat (PC) tick();
    oe_n = 1'b1;
  endtask

  task automatic read_cyc(input logic [AW-1:0] a, output logic [DW-1:0] got,
                          output int lat);
    lat = -1; got = '0;
    addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    for (int i = 1; i <= AC + 3; i++) begin
      @(negedge clk);
      if (dout_en && lat < 0) begin lat = i; got = dout; end
      #1;
      addr = a ^ AW'(i * 37 + 1);
    end
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [DW-1:0] e,
                             input string req);
    logic [DW-1:0] got;
    int lat;
    read_cyc(a, got, lat);
    chk(lat == AC + 1, "R6", "read latency", lat, AC + 1);
    chk(got == e, req, "read data", int'(got), int'(e));
    repeat (PC + 1) tick();
  endtask

  initial begin
    logic [DW-1:0] got;
    int lat;
    do_reset();
    @(negedge clk);
    chk(dout_en == 1'b0, "R10", "dout_en after reset", int'(dout_en), 0);
    chk(protocol_error == 1'b0, "R10", "error after reset", int'(protocol_error), 0);
    #1;

    // R1 / R3 / R2: silent writes, address changed after the start edge.
    write_ce(10'h005, 8'hA5);
    write_ce(10'h3FF, 8'h3C);
    write_ce(10'h000, 8'hC3);
    read_expect(10'h005, 8'hA5, "R2");
    read_expect(10'h3FF, 8'h3C, "R1");
    read_expect(10'h000, 8'hC3, "R1");

    // R4 / R5: read turning into a write, last din before rise wins.
    addr = 10'h005; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
    repeat (AC) tick();
    @(negedge clk);
    chk(dout_en == 1'b1, "R4", "drive before we_n low", int'(dout_en), 1);
    chk(dout == 8'hA5, "R4", "old data before write", int'(dout), 8'hA5);
    #1;
    we_n = 1'b0; din = 8'h11;
    @(negedge clk);
    chk(dout_en == 1'b0, "R4", "drive after we_n low", int'(dout_en), 0);
    #1;
    din = 8'h77;
    tick();
    we_n = 1'b1;
    @(negedge clk);
    chk(dout_en == 1'b0, "R4", "drive after write ended", int'(dout_en), 0);
    #1;
    we_n = 1'b0; din = 8'h5A;
    tick();
    we_n = 1'b1;
    tick();
    recover();
    read_expect(10'h005, 8'h77, "R5");

    // R5: write ended by chip enable while we_n still low.
    addr = 10'h0AA; we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
    tick();
    we_n = 1'b0; din = 8'h90;
    repeat (AC + 1) tick();
    din = 8'h91;
    ce_n = 1'b1;
    tick();
    we_n = 1'b1; din = 8'h00;
    repeat (PC) tick();
    read_expect(10'h0AA, 8'h91, "R5");

    // R2: ce_n held low for a long time starts nothing new.
    addr = 10'h3FF; oe_n = 1'b0; ce_n = 1'b0;
    repeat (AC + 8) tick();
    @(negedge clk);
    chk(dout == 8'h3C, "R2", "held-low data", int'(dout), 8'h3C);
    chk(protocol_error == 1'b0, "R2", "held-low error", int'(protocol_error), 0);
    #1;
    recover();

    // R9: early release, no drive, cycle still completes then recovers.
    addr = 10'h000; oe_n = 1'b0; ce_n = 1'b0;
    tick();
    ce_n = 1'b1;
    for (int i = 0; i < AC + PC + 2; i++) begin
      @(negedge clk);
      chk(dout_en == 1'b0, "R9", "early release drive", int'(dout_en), 0);
      #1;
    end
    chk(protocol_error == 1'b0, "R9", "early release error", int'(protocol_error), 0);
    oe_n = 1'b1;
    read_expect(10'h000, 8'hC3, "R9");

    // R7: start exactly at the minimum recovery gap is accepted.
    read_cyc(10'h3FF, got, lat);
    repeat (PC + 1) tick();
    read_cyc(10'h3FF, got, lat);
    chk(lat == AC + 1, "R7", "min-gap latency", lat, AC + 1);
    chk(protocol_error == 1'b0, "R7", "min-gap error", int'(protocol_error), 0);

    // R8: one clock short of the gap is rejected and ignored.
    repeat (PC) tick();
    addr = 10'h005; oe_n = 1'b0; ce_n = 1'b0;
    tick();
    @(negedge clk);
    chk(protocol_error == 1'b1, "R8", "short-gap error", int'(protocol_error), 1);
    #1;
    for (int i = 0; i < AC + 3; i++) begin
      @(negedge clk);
      chk(dout_en == 1'b0, "R8", "rejected start drives", int'(dout_en), 0);
      #1;
    end
    recover();
    read_cyc(10'h005, got, lat);
    chk(got == 8'h77, "R8", "read after reject", int'(got), 8'h77);
    chk(protocol_error == 1'b1, "R8", "error sticky", int'(protocol_error), 1);
    repeat (PC + 1) tick();

    // R10 / R1: reset clears the flag, array keeps its contents.
    do_reset();
    @(negedge clk);
    chk(protocol_error == 1'b0, "R10", "error after re-reset", int'(protocol_error), 0);
    #1;
    read_expect(10'h0AA, 8'h91, "R1");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule